// File: doc/BRIEF.md
# Multi-Slot Receive Timestamp Latch

This block freezes the free-running time counter when a timing packet arrives. The receive path raises a capture request for each qualifying packet. The block stores the counter value in the lowest-numbered empty slot of a small bank and returns the slot number in the same cycle. That number travels with the packet, so the host can later fetch the matching timestamp. A separate single-entry latch captures transmit timestamps. It can raise an interrupt while it holds a value.

The host reaches the block through a plain register port. One control register sets the global enable, the sync message version, receive-side UDP recognition and the transmit interrupt enable. A status register shows which latches hold a value. Each latch is read as a low word and then a high word. Reading the high word releases the latch. While every receive slot is occupied, further receive requests are refused until the host releases one.

Capture requests use a valid/ready pair. The packet path does not wait: a request seen with ready low is lost, and that packet goes unstamped. Ready depends only on the control register and the occupancy of the latches, never on valid.

Top module: `rx_ts_latch`

## Requirements
- R1: After reset, the control register and the status register read 0, both capture ready outputs are low and `tx_irq` is low.
- R2: An accepted receive request is stored in the lowest-numbered empty slot. `rx_slot` gives that slot number in the same cycle as `rx_req_ready`. The status register shows slot i occupied at bit i.
- R3: A slot keeps the `time_in` value present in the cycle its request was accepted. Slot i is read at address 4+2i (low 32 bits) and at address 5+2i (high 32 bits).
- R4: Reading a slot's low word does not change its occupancy or its stored value.
- R5: Reading a slot's high word returns the high bits and releases the slot. Its status bit is clear on the next read, and a later request may reuse the slot.
- R6: While all slots are occupied, `rx_req_ready` is low. A request made then changes neither the status nor any stored value.
- R7: Control bit 0 is the global enable and bit 1 is UDP recognition. Bits 3:2 hold the sync version (1 or 2). Receive capture is allowed only when bit 0 is set and either the version is 2, or the version is 1 with bit 1 set. Version 1 without UDP, version 0 and version 3 suppress all receive captures.
- R8: The transmit latch accepts a request only when bit 0 is set and the latch is empty. It shows occupancy at status bit 16. It is read at address 2 (low) and address 3 (high), and reading address 3 releases it.
- R9: `tx_irq` is high exactly while the transmit latch is occupied and control bit 4 is set.
- R10: Read data appears on `host_rdata` one cycle after `host_rd`. Control bits 4:0 read back as written, with the upper bits reading 0. A write to any address other than 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_in | input | 64 | Free-running time counter, in nanoseconds |
| rx_req_valid | input | 1 | Receive capture request for a qualifying packet |
| rx_req_ready | output | 1 | Receive capture possible this cycle |
| rx_slot | output | 2 | Slot that takes the receive capture |
| tx_req_valid | input | 1 | Transmit capture request |
| tx_req_ready | output | 1 | Transmit capture possible this cycle |
| tx_irq | output | 1 | Transmit timestamp available interrupt |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data, one cycle after the read |

## Verification
A slot whose occupied flag is wrong shows up quickly at the ports. If it is wrongly clear, `rx_slot` names it in the same cycle as the next request, and an earlier stamp is overwritten. If it is wrongly set, the slot is skipped, and the full condition arrives one request early. A stamp taken at the wrong edge, or a slot released by a low-word read, appears in the very next register read. A stuck transmit flag shows at `tx_irq` and `tx_req_ready` in the cycle after the high-word read.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    VER_NONE = 2'd0,
    VER_ONE  = 2'd1,
    VER_TWO  = 2'd2,
    VER_RSVD = 2'd3
  } sync_ver_e;

  // bit4 tx irq enable, bits3:2 version, bit1 udp, bit0 enable
  typedef struct packed {
    logic      tx_irq_en;
    sync_ver_e ver;
    logic      udp_en;
    logic      enable;
  } ctrl_t;

  localparam int CTRL_W      = $bits(ctrl_t);
  localparam int STAT_TX_BIT = 16;
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_STAT   = 1;
  localparam int ADDR_TX_LO  = 2;
  localparam int ADDR_TX_HI  = 3;
  localparam int ADDR_RX_0   = 4;

  function automatic logic rx_allowed(ctrl_t c);
    return c.enable && ((c.ver == VER_TWO) || (c.ver == VER_ONE && c.udp_en));
  endfunction
endpackage

// File: rtl/tsl_slot.sv
module tsl_slot #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set,
  input  logic            clr,
  input  logic [TS_W-1:0] time_in,
  output logic            busy,
  output logic [TS_W-1:0] stamp
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      stamp <= '0;
    end else if (set) begin
      busy  <= 1'b1;
      stamp <= time_in;
    end else if (clr) begin
      busy  <= 1'b0;
    end
  end

  // R6
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |-> !busy);
  // R5
  hi_read_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !busy);
  // R4
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !set) |=> (stamp == $past(stamp)));
endmodule

// File: rtl/tsl_alloc.sv
module tsl_alloc #(
  parameter int N_SLOTS = 4,
  localparam int SW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] busy,
  input  logic               gate,
  output logic               ready,
  output logic [SW-1:0]      idx
);
  always_comb begin
    idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (!busy[i]) idx = SW'(i);
    end
  end

  assign ready = gate && !(&busy);

  // R2
  free_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy[idx]);
  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !ready);
endmodule

// File: rtl/tsl_regs.sv
module tsl_regs
  import tsl_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DW      = 32,
  localparam int TS_W   = 2 * DW,
  localparam int AW     = $clog2(ADDR_RX_0 + 2 * N_SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic [AW-1:0]                host_addr,
  input  logic [DW-1:0]                host_wdata,
  output logic [DW-1:0]                host_rdata,
  input  logic [N_SLOTS-1:0]           rx_busy,
  input  logic [N_SLOTS-1:0][TS_W-1:0] rx_stamp,
  input  logic                         tx_busy,
  input  logic [TS_W-1:0]              tx_stamp,
  output logic [N_SLOTS-1:0]           rx_free,
  output logic                         tx_free,
  output ctrl_t                        ctrl
);
  logic [DW-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (host_wr && host_addr == AW'(ADDR_CTRL)) ctrl <= ctrl_t'(host_wdata[CTRL_W-1:0]);
  end

  always_comb begin
    rd_next = '0;
    if (host_addr == AW'(ADDR_CTRL)) rd_next[CTRL_W-1:0] = ctrl;
    if (host_addr == AW'(ADDR_STAT)) begin
      rd_next[N_SLOTS-1:0] = rx_busy;
      rd_next[STAT_TX_BIT] = tx_busy;
    end
    if (host_addr == AW'(ADDR_TX_LO)) rd_next = tx_stamp[DW-1:0];
    if (host_addr == AW'(ADDR_TX_HI)) rd_next = tx_stamp[TS_W-1:DW];
    for (int i = 0; i < N_SLOTS; i++) begin
      if (host_addr == AW'(ADDR_RX_0 + 2 * i))     rd_next = rx_stamp[i][DW-1:0];
      if (host_addr == AW'(ADDR_RX_0 + 2 * i + 1)) rd_next = rx_stamp[i][TS_W-1:DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_next;
  end

  genvar g;
  generate
    for (g = 0; g < N_SLOTS; g++) begin : g_free
      assign rx_free[g] = host_rd && host_addr == AW'(ADDR_RX_0 + 2 * g + 1);
    end
  endgenerate
  assign tx_free = host_rd && host_addr == AW'(ADDR_TX_HI);

  // R10
  ctrl_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr != AW'(ADDR_CTRL)) |=> ctrl == $past(ctrl));
endmodule

// File: rtl/rx_ts_latch.sv
module rx_ts_latch
  import tsl_pkg::*;
#(
  parameter int N_SLOTS = 4,
  parameter int DW      = 32,
  localparam int TS_W   = 2 * DW,
  localparam int SW     = $clog2(N_SLOTS),
  localparam int AW     = $clog2(ADDR_RX_0 + 2 * N_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] time_in,
  input  logic            rx_req_valid,
  output logic            rx_req_ready,
  output logic [SW-1:0]   rx_slot,
  input  logic            tx_req_valid,
  output logic            tx_req_ready,
  output logic            tx_irq,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [AW-1:0]   host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata
);
  ctrl_t                        ctrl;
  logic [N_SLOTS-1:0]           rx_busy, rx_free, rx_set;
  logic [N_SLOTS-1:0][TS_W-1:0] rx_stamp;
  logic                         tx_busy, tx_free, tx_set;
  logic [TS_W-1:0]              tx_stamp;

  tsl_alloc #(.N_SLOTS(N_SLOTS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .busy(rx_busy), .gate(rx_allowed(ctrl)),
    .ready(rx_req_ready), .idx(rx_slot)
  );

  genvar g;
  generate
    for (g = 0; g < N_SLOTS; g++) begin : g_slot
      assign rx_set[g] = rx_req_valid && rx_req_ready && (rx_slot == SW'(g));
      tsl_slot #(.TS_W(TS_W)) u_slot (
        .clk(clk), .rst_n(rst_n), .set(rx_set[g]), .clr(rx_free[g]),
        .time_in(time_in), .busy(rx_busy[g]), .stamp(rx_stamp[g])
      );
    end
  endgenerate

  assign tx_req_ready = ctrl.enable && !tx_busy;
  assign tx_set       = tx_req_valid && tx_req_ready;

  tsl_slot #(.TS_W(TS_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .set(tx_set), .clr(tx_free),
    .time_in(time_in), .busy(tx_busy), .stamp(tx_stamp)
  );

  assign tx_irq = tx_busy && ctrl.tx_irq_en;

  tsl_regs #(.N_SLOTS(N_SLOTS), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rx_busy(rx_busy), .rx_stamp(rx_stamp), .tx_busy(tx_busy),
    .tx_stamp(tx_stamp), .rx_free(rx_free), .tx_free(tx_free), .ctrl(ctrl)
  );

  // R3
  rx_stamp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req_valid && rx_req_ready) |=>
      (rx_busy[$past(rx_slot)] && rx_stamp[$past(rx_slot)] == $past(time_in)));
  // R2
  one_new_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rx_busy & ~$past(rx_busy)) <= 1);
  // R8
  tx_stamp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_valid && tx_req_ready) |=> (tx_busy && tx_stamp == $past(time_in)));
  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.enable || ctrl.ver == VER_NONE || ctrl.ver == VER_RSVD) |-> !rx_req_ready);
endmodule

// File: tb/rx_ts_latch_test.sv
module rx_ts_latch_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_in = '0;
  logic        rx_req_valid = 1'b0, tx_req_valid = 1'b0;
  logic        rx_req_ready, tx_req_ready, tx_irq;
  logic [1:0]  rx_slot;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_ts_latch uut (
    .clk(clk), .rst_n(rst_n), .time_in(time_in),
    .rx_req_valid(rx_req_valid), .rx_req_ready(rx_req_ready), .rx_slot(rx_slot),
    .tx_req_valid(tx_req_valid), .tx_req_ready(tx_req_ready), .tx_irq(tx_irq),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int a, logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = 4'(a); host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic reg_rd(int a, output logic [31:0] d);
    @(negedge clk); host_rd = 1'b1; host_addr = 4'(a);
    @(posedge clk); #1 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic rx_cap(logic [63:0] t, logic exp_rdy, int exp_slot, string req);
    @(negedge clk); rx_req_valid = 1'b1; time_in = t;
    #1;
    chk(req, {63'd0, rx_req_ready}, {63'd0, exp_rdy});
    if (exp_rdy) chk(req, 64'(rx_slot), 64'(exp_slot));
    @(negedge clk); rx_req_valid = 1'b0; time_in = t + 64'd77;
  endtask

  task automatic tx_cap(logic [63:0] t, logic exp_rdy, string req);
    @(negedge clk); tx_req_valid = 1'b1; time_in = t;
    #1 chk(req, {63'd0, tx_req_ready}, {63'd0, exp_rdy});
    @(negedge clk); tx_req_valid = 1'b0; time_in = t + 64'd5;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    #1;
    chk("R1 rx ready", {63'd0, rx_req_ready}, 64'd0);
    chk("R1 tx ready", {63'd0, tx_req_ready}, 64'd0);
    chk("R1 irq", {63'd0, tx_irq}, 64'd0);
    reg_rd(1, d); chk("R1 status", 64'(d), 64'd0);
    reg_rd(0, d); chk("R1 ctrl", 64'(d), 64'd0);
  endtask

  task automatic t_fill_and_free;
    logic [31:0] d;
    logic [63:0] ts [4];
    reg_wr(0, 32'h9);
    for (int k = 0; k < 4; k++) begin
      ts[k] = 64'h1000_0000_A000_0000 + 64'(k) * 64'h0101_0000_0011;
      rx_cap(ts[k], 1'b1, k, "R2 lowest slot");
    end
    reg_rd(1, d); chk("R2 status full", 64'(d), 64'hF);
    rx_cap(64'hDEAD, 1'b0, 0, "R6 full refuses");
    reg_rd(1, d); chk("R6 status unchanged", 64'(d), 64'hF);
    reg_rd(6, d); chk("R3 slot1 low", 64'(d), 64'(ts[1][31:0]));
    reg_rd(1, d); chk("R4 low read keeps slot", 64'(d), 64'hF);
    reg_rd(7, d); chk("R5 slot1 high", 64'(d), 64'(ts[1][63:32]));
    reg_rd(1, d); chk("R5 slot1 freed", 64'(d), 64'hD);
    reg_rd(4, d); chk("R6 slot0 kept", 64'(d), 64'(ts[0][31:0]));
    rx_cap(64'h2222_3333_4444_5555, 1'b1, 1, "R5 reuse slot1");
    reg_rd(6, d); chk("R3 new low", 64'(d), 64'h4444_5555);
    reg_rd(7, d); chk("R3 new high", 64'(d), 64'h2222_3333);
    reg_rd(9, d); chk("R3 slot2 high", 64'(d), 64'(ts[2][63:32]));
    reg_rd(1, d); chk("R5 status", 64'(d), 64'h9);
    reg_rd(5, d); reg_rd(11, d); chk("R3 slot3 high", 64'(d), 64'(ts[3][63:32]));
    reg_rd(1, d); chk("R5 all freed", 64'(d), 64'h0);
  endtask

  task automatic t_filter;
    logic [31:0] d;
    reg_wr(0, 32'h5);
    rx_cap(64'h55, 1'b0, 0, "R7 v1 no udp");
    reg_rd(1, d); chk("R7 nothing captured", 64'(d), 64'h0);
    #1 chk("R7 tx unaffected", {63'd0, tx_req_ready}, 64'd1);
    reg_wr(0, 32'h7);
    rx_cap(64'h66, 1'b1, 0, "R7 v1 with udp");
    reg_wr(0, 32'hD);
    rx_cap(64'h77, 1'b0, 0, "R7 version 3");
    reg_wr(0, 32'h8);
    rx_cap(64'h88, 1'b0, 0, "R7 enable off");
    reg_rd(1, d); chk("R7 one capture", 64'(d), 64'h1);
    reg_rd(5, d);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    reg_wr(0, 32'h11);
    tx_cap(64'hABCD_0001_1234_5678, 1'b1, "R8 tx accept");
    #1 chk("R9 irq set", {63'd0, tx_irq}, 64'd1);
    reg_rd(1, d); chk("R8 tx status", 64'(d), 64'h1_0000);
    tx_cap(64'h999, 1'b0, "R8 tx busy refuse");
    reg_rd(2, d); chk("R8 tx low", 64'(d), 64'h1234_5678);
    #1 chk("R9 irq after low", {63'd0, tx_irq}, 64'd1);
    reg_rd(3, d); chk("R8 tx high", 64'(d), 64'hABCD_0001);
    #1 chk("R9 irq cleared", {63'd0, tx_irq}, 64'd0);
    reg_wr(0, 32'h1);
    tx_cap(64'h4242, 1'b1, "R8 tx accept no ie");
    #1 chk("R9 irq masked", {63'd0, tx_irq}, 64'd0);
    reg_rd(2, d); chk("R8 tx low 2", 64'(d), 64'h4242);
    reg_rd(3, d); reg_rd(1, d); chk("R8 tx freed", 64'(d), 64'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    reg_wr(0, 32'hFFFF_FFFF);
    reg_rd(0, d); chk("R10 ctrl mask", 64'(d), 64'h1F);
    reg_wr(1, 32'hFFFF_FFFF);
    reg_wr(5, 32'h0);
    reg_rd(0, d); chk("R10 ctrl kept", 64'(d), 64'h1F);
    reg_rd(1, d); chk("R10 status not writable", 64'(d), 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_fill_and_free();
    t_filter();
    t_tx();
    t_regs();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule